// File: doc/BRIEF.md
# Sampling Converter Bus and Conversion Controller

This block is the digital front end of a sampling successive-approximation converter. It watches three active-low strobes (convert, chip-select, read) and a static two-bit mode selection. From these it decides when a conversion begins, and it drives a track/hold control line for the duration of that conversion. It passes the start to a separate bit-decision engine through a start pulse and a done handshake. It keeps the last result in a register, which it places on a 12-bit three-state bus during a read.

A single status output carries either interrupt or busy meaning, depending on the mode. The same start logic covers several board wirings:
- read and chip-select tied low, so the convert strobe starts conversions;
- convert tied low, so each read starts a conversion and returns the result of the previous one;
- all strobes held low in the continuous mode, so the block converts back to back with a fixed acquisition gap.

The strobes are synchronised to the clock before their edges are used. The start therefore lags the strobe by two to three clocks.

Top module: `adc_bus_ctrl`

## Requirements
- R1: A conversion starts only when convert, chip-select and read are all low (as seen after the two-flop synchroniser). In the single-shot modes it starts on the falling edge that completes that condition. The hold output rises on the third rising clock edge after the completing strobe falls in the low clock phase. Convert low alone, or read and chip-select low with convert high, starts nothing.
- R2: While a conversion is in progress, further strobe edges neither restart it nor queue a new one.
- R3: The data bus carries the result register whenever read and chip-select are both low (combinational, no clock). Otherwise every bit of the bus is high-impedance.
- R4: With modeSel = 2'b00 (interrupt mode), statusN stays high during a conversion and falls on the clock edge that accepts sarDone. After a new read (read and chip-select both low), it returns high by the third rising edge.
- R5: With modeSel = 2'b01, 2'b10 or 2'b11 (busy modes), statusN is low exactly while a conversion is in progress. The new result is on the bus in the same cycle that statusN returns high.
- R6: With modeSel = 2'b10 (continuous mode) and all strobes low, the block starts a new conversion after exactly 2 tracking clocks following each accepted sarDone. With an engine that answers 11 clocks after sarStart, the hold output is high for 12 clocks and low for 2, a period of 14.
- R7: In continuous mode, raising any strobe lets the running conversion finish, and no further conversion starts.
- R8: The result register changes only on the edge that accepts sarDone. During a conversion the previous result stays readable on the bus.
- R9: With convert held low in a busy single-shot mode, a read immediately returns the previous result, and it also starts a conversion whose result the next read returns.
- R10: The hold output is high exactly while a conversion is in progress. sarStart is a one-cycle pulse in the first hold cycle.
- R11: After reset: hold low, statusN high, sarStart low, result register zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | Static mode: 00 interrupt single-shot, 01/11 busy single-shot, 10 busy continuous |
| convN | input | 1 | Active-low convert strobe (asynchronous) |
| csN | input | 1 | Active-low chip-select (asynchronous) |
| rdN | input | 1 | Active-low read strobe (asynchronous) |
| sarDone | input | 1 | Bit-decision engine reports its result valid |
| sarResult | input | 12 | Result word from the bit-decision engine |
| sarStart | output | 1 | One-cycle start pulse to the bit-decision engine |
| holdOut | output | 1 | Track/hold control, high = hold |
| statusN | output | 1 | Interrupt or busy status, active low |
| dataBus | output | 12 | Three-state result bus |

## Verification
The start logic is exercised with the convert strobe alone and with read and chip-select alone, neither of which may start anything. It is also exercised with chip-select as the last strobe to fall, which separates a correct three-way condition from one that watches a single pin. A convert toggle in the middle of a conversion shows whether edges are ignored or queued. Continuous runs measure the 12/2 hold pattern and then the halt after one strobe rises. A read-driven sequence with convert tied low checks that the first read returns the stale word and the second returns the fresh one. Random convert toggling with the bus enabled compares the bus against the engine's last word, and the status against the hold line, on every cycle.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  typedef enum logic [1:0] {
    MODE_INT_SINGLE  = 2'b00,
    MODE_BUSY_SINGLE = 2'b01,
    MODE_BUSY_CONT   = 2'b10,
    MODE_BUSY_ALT    = 2'b11
  } convMode_t;

  // strobes from the control to the result datapath
  typedef struct packed {
    logic loadResult;
    logic busEnable;
  } pathCmd_t;

endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncN,
  output logic [WIDTH-1:0] syncN
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], asyncN[b]};
    end
    assign syncN[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int ACQ_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  convMode_t modeSel,
  input  logic      convS,
  input  logic      csS,
  input  logic      rdS,
  input  logic      rdN,
  input  logic      csN,
  input  logic      sarDone,
  output logic      busy,
  output logic      sarStart,
  output logic      statusN,
  output pathCmd_t  cmd
);

  localparam int ACQ_W = $clog2(ACQ_CYC + 1);
  localparam logic [ACQ_W-1:0] ACQ_LOAD = ACQ_W'(ACQ_CYC - 1);

  logic             startCond;
  logic             startCondQ;
  logic             readAct;
  logic             readActQ;
  logic             readEdge;
  logic             intPend;
  logic             contMode;
  logic             acceptDone;
  logic             startReq;
  logic [ACQ_W-1:0] acqCnt;

  assign startCond  = !convS && !csS && !rdS;
  assign readAct    = !rdS && !csS;
  assign readEdge   = readAct && !readActQ;
  assign contMode   = (modeSel == MODE_BUSY_CONT);
  assign acceptDone = busy && sarDone;

  always_comb begin
    startReq = 1'b0;
    if (!busy) begin
      if (contMode) startReq = startCond && (acqCnt == '0);
      else          startReq = startCond && !startCondQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      sarStart   <= 1'b0;
      startCondQ <= 1'b0;
      readActQ   <= 1'b0;
      acqCnt     <= '0;
      intPend    <= 1'b0;
    end else begin
      startCondQ <= startCond;
      readActQ   <= readAct;
      sarStart   <= startReq;
      if (acceptDone)    busy <= 1'b0;
      else if (startReq) busy <= 1'b1;
      if (acceptDone)          acqCnt <= ACQ_LOAD;
      else if (acqCnt != '0)   acqCnt <= acqCnt - 1'b1;
      if (acceptDone)    intPend <= 1'b1;
      else if (readEdge) intPend <= 1'b0;
    end
  end

  assign statusN        = (modeSel == MODE_INT_SINGLE) ? !intPend : !busy;
  assign cmd.loadResult = acceptDone;
  assign cmd.busEnable  = !rdN && !csN;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    busy && !sarDone |=> !sarStart) else $error("restart during conversion"); // R2

  AST_START_NEEDS_CONV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(convS)) else $error("start without convert low"); // R1

  AST_INT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_INT_SINGLE) && acceptDone |=> !statusN) else $error("interrupt not raised"); // R4

  AST_ACQ_GAP: assert property (@(posedge clk) disable iff (!rstN)
    contMode && $fell(busy) |=> !busy) else $error("acquisition gap too short"); // R6

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sarStart |=> !sarStart) else $error("start pulse too long"); // R10

endmodule

// File: rtl/adc_result_path.sv
module adc_result_path
  import adc_ctl_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCmd_t          cmd,
  input  logic [DATA_W-1:0] sarResult,
  output logic [DATA_W-1:0] dataBus
);

  logic [DATA_W-1:0] resultReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               resultReg <= '0;
    else if (cmd.loadResult) resultReg <= sarResult;
  end

  assign dataBus = cmd.busEnable ? resultReg : {DATA_W{1'bz}};

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int ACQ_CYC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              convN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              sarDone,
  input  logic [DATA_W-1:0] sarResult,
  output logic              sarStart,
  output logic              holdOut,
  output logic              statusN,
  output logic [DATA_W-1:0] dataBus
);

  logic [2:0] strobeS;
  logic       busy;
  pathCmd_t   cmd;

  adc_strobe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rstN  (rstN),
    .asyncN({convN, csN, rdN}),
    .syncN (strobeS)
  );

  adc_conv_ctrl #(.ACQ_CYC(ACQ_CYC)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (convMode_t'(modeSel)),
    .convS   (strobeS[2]),
    .csS     (strobeS[1]),
    .rdS     (strobeS[0]),
    .rdN     (rdN),
    .csN     (csN),
    .sarDone (sarDone),
    .busy    (busy),
    .sarStart(sarStart),
    .statusN (statusN),
    .cmd     (cmd)
  );

  adc_result_path #(.DATA_W(DATA_W)) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .sarResult(sarResult),
    .dataBus  (dataBus)
  );

  assign holdOut = busy;

  AST_OLD_DATA_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    holdOut && !sarDone && !rdN && !csN |=> (rdN || csN || $stable(dataBus)))
    else $error("result changed mid conversion"); // R8

  AST_START_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    sarStart |-> holdOut) else $error("start pulse outside hold"); // R10

endmodule

// File: tb/test_adc_bus_ctrl.sv
module test_adc_bus_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 12;
  localparam int ENG_LAT    = 11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        modeSel = 2'b01;
  logic              convN = 1'b1;
  logic              csN = 1'b1;
  logic              rdN = 1'b1;
  logic              sarDone;
  logic [DATA_W-1:0] sarResult;
  logic              sarStart;
  logic              holdOut;
  logic              statusN;
  logic [DATA_W-1:0] dataBus;

  int nCheck = 0;
  int nFail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_ctrl i_adc_bus_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .convN(convN), .csN(csN), .rdN(rdN),
    .sarDone(sarDone), .sarResult(sarResult), .sarStart(sarStart),
    .holdOut(holdOut), .statusN(statusN), .dataBus(dataBus)
  );

  // bit-decision engine model: answers ENG_LAT clocks after a start pulse
  logic [3:0]        engCnt;
  logic [DATA_W-1:0] engPend;
  logic [DATA_W-1:0] lastWord;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engCnt   <= '0;
      engPend  <= '0;
      lastWord <= '0;
    end else begin
      if (sarStart) begin
        engCnt  <= 4'(ENG_LAT);
        engPend <= DATA_W'($urandom);
      end else if (engCnt != 0) engCnt <= engCnt - 1'b1;
      if (engCnt == 4'd1) lastWord <= engPend;
    end
  end
  assign sarDone   = (engCnt == 4'd1);
  assign sarResult = engPend;

  function automatic logic [DATA_W-1:0] zWord();
    return {DATA_W{1'bz}};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nCheck++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DATA_W-1:0] prevWord;
    void'($urandom(32'd1234));
    tick(3);
    // R11 reset state
    check("R11 hold", holdOut, 0);
    check("R11 status", statusN, 1);
    check("R11 start", sarStart, 0);
    check("R3 bus idle z", dataBus, zWord());
    rstN = 1'b1;
    tick(2);

    // R1 / R11: read with convert high returns the reset result, no start
    rdN = 0; csN = 0; #1;
    check("R11 result zero", dataBus, 0);
    tick(6);
    check("R1 no start rd/cs only", holdOut, 0);
    rdN = 1; csN = 1; #1;
    check("R3 bus released", dataBus, zWord());
    convN = 0;
    tick(6);
    check("R1 no start convert only", holdOut, 0);
    rdN = 0;
    tick(6);
    check("R1 no start two strobes", holdOut, 0);
    csN = 0;  // completes the condition
    tick(2);
    check("R1 latency early", holdOut, 0);
    tick(1);
    check("R1 start", holdOut, 1);
    check("R10 start pulse", sarStart, 1);
    check("R5 busy low", statusN, 0);
    prevWord = lastWord;
    // R2: toggle convert mid conversion
    convN = 1; tick(2);
    check("R10 pulse single", sarStart, 0);
    convN = 0; tick(2);
    tick(7);
    check("R8 old data held", dataBus, prevWord);
    check("R5 still busy", statusN, 0);
    tick(1);
    check("R5 status released", statusN, 1);
    check("R5 new data", dataBus, lastWord);
    check("R10 hold ends", holdOut, 0);
    tick(10);
    check("R2 no queued restart", holdOut, 0);
    convN = 1; rdN = 1; csN = 1;
    tick(4);

    // R4 interrupt mode
    modeSel = 2'b00;
    tick(2);
    rdN = 0; csN = 0; convN = 0;
    tick(3);
    check("R4 start", holdOut, 1);
    convN = 1;
    tick(11);
    check("R4 high while converting", statusN, 1);
    tick(1);
    check("R4 falls at done", statusN, 0);
    check("R3 result on bus", dataBus, lastWord);
    rdN = 1; csN = 1;
    tick(1);
    check("R3 z after read", dataBus, zWord());
    check("R4 held until read", statusN, 0);
    tick(2);
    rdN = 0; csN = 0;
    tick(2);
    check("R4 not yet cleared", statusN, 0);
    tick(1);
    check("R4 cleared by read", statusN, 1);
    check("R1 read alone no start", holdOut, 0);
    rdN = 1; csN = 1;
    tick(4);

    // R6 / R7 continuous mode
    modeSel = 2'b10;
    tick(2);
    rdN = 0; csN = 0; convN = 0;
    tick(3);
    check("R6 first start", holdOut, 1);
    tick(11);
    check("R6 hold 12 cycles", holdOut, 1);
    tick(1);
    check("R6 track 1", holdOut, 0);
    check("R5 cont result", dataBus, lastWord);
    tick(1);
    check("R6 track 2", holdOut, 0);
    tick(1);
    check("R6 restart after 2", holdOut, 1);
    csN = 1;
    tick(11);
    check("R7 finishes", holdOut, 1);
    tick(1);
    check("R7 ends", holdOut, 0);
    tick(20);
    check("R7 halted", holdOut, 0);
    rdN = 1; convN = 1;
    tick(4);

    // R9 read-started mode
    modeSel = 2'b01;
    convN = 0;
    tick(3);
    prevWord = lastWord;
    rdN = 0; csN = 0; #1;
    check("R9 first read stale", dataBus, prevWord);
    tick(1);
    rdN = 1; csN = 1;
    tick(2);
    check("R9 read starts", holdOut, 1);
    tick(12);
    check("R9 done", holdOut, 0);
    rdN = 0; csN = 0; #1;
    check("R9 second read fresh", dataBus, lastWord);
    tick(1);
    rdN = 1; csN = 1;
    tick(20);
    convN = 1;
    tick(4);

    // random convert toggling, bus enabled (stand-alone wiring)
    modeSel = 2'b01;
    rdN = 0; csN = 0;
    for (int k = 0; k < 300; k++) begin
      convN = 1'($urandom_range(0, 1));
      for (int j = 0; j < int'($urandom_range(1, 20)); j++) begin
        tick(1);
        check("R8 bus tracks last word", dataBus, lastWord);
        check("R5 status vs hold", statusN, !holdOut);
      end
    end
    summary();
  end

endmodule